// File: doc/BRIEF.md
# Processor Interrupt Level Tracker

The tracker sits between an interrupt controller that presents a vector of pending interrupt levels and the trap logic of a processor. Each cycle it finds the most urgent pending level and turns it into a trap index in the external-interrupt class. It holds that index as the processor's current trap index, and it tells the processor when a different external interrupt has been chosen.

The tracker only reconsiders its choice while the current index is idle (zero) or already an external-interrupt trap. A trap of another class, loaded by the processor, is never displaced by interrupt activity. When all levels drop while an external-interrupt trap is current, the index returns to idle and the request is withdrawn. When the processor takes a trap, the index and the request clear. Vectoring, priority masking and acknowledge signalling belong to neighbouring blocks and are not part of this one.

All pins are plain control and status signals with no handshake. The level vector is sampled on every clock edge and cannot apply back-pressure. `trap_load` and `trap_taken` are single-cycle strobes.

Top module: `pil_tracker`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `trap_idx` is 0 and `irq_req` and `irq_new` are 0.
- R2: Levels are ranked from bit 15 (most urgent) down to bit 1. Bit 0 of `lvl_pend` never causes a selection. The selected index is `EXT_BASE` (default 0x10, low four bits zero) ORed with the level number in bits 3:0.
- R3: `irq_new` pulses for exactly one cycle, and `irq_req` is set, on the edge at which the selected index differs from the previous `trap_idx`. If the same index is re-selected, or a less urgent level is added, there is no pulse.
- R4: Selection updates `trap_idx` only when the current index is 0 or its bits 7:4 equal those of `EXT_BASE`.
- R5: When bits 15:1 of `lvl_pend` are all zero and the current index is in the external class, the next edge sets `trap_idx` to 0 and clears `irq_req`.
- R6: A current index that is nonzero and outside the external class stays unchanged whatever `lvl_pend` does, and no pulse is raised.
- R7: `trap_taken` takes priority over every other input. On the next edge it clears `trap_idx` and `irq_req`.
- R8: `trap_load` (when `trap_taken` is low) writes `trap_code` into `trap_idx` without raising `irq_new` and without changing `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_pend | input | 16 | Pending interrupt levels, bit 0 unused |
| trap_load | input | 1 | Strobe: load `trap_code` as current index |
| trap_code | input | 8 | Trap index loaded by `trap_load` |
| trap_taken | input | 1 | Strobe: processor has taken the current trap |
| trap_idx | output | 8 | Current trap index |
| irq_req | output | 1 | Hard-interrupt request level |
| irq_new | output | 1 | One-cycle pulse when a new external trap is chosen |

## Verification
The assertions assume that `trap_taken` and `trap_load` are single-cycle strobes and that `EXT_BASE` has zero low bits. They also treat a loaded `trap_code` as being in any class the processor chooses, including the external one. The stimulus drives every input at the falling edge. It raises each strobe for one cycle only, and it loads only codes outside the external class when it tests that such traps are protected. The level patterns cover an empty vector, bit 0 alone, single levels, added more urgent levels and added less urgent levels.

// File: rtl/pil_pkg.sv
package pil_pkg;

  typedef enum logic [2:0] {
    ACT_HOLD   = 3'd0,
    ACT_TAKEN  = 3'd1,
    ACT_LOAD   = 3'd2,
    ACT_SELECT = 3'd3,
    ACT_CLEAR  = 3'd4
  } pil_act_e;

endpackage

// File: rtl/pil_prio_enc.sv
module pil_prio_enc #(
  parameter int NLVL = 16,
  localparam int LVLW = $clog2(NLVL)
) (
  input  logic [NLVL-1:0] vec,
  output logic            any,
  output logic [LVLW-1:0] sel
);
  logic [NLVL-1:0] upper_busy;

  // upper_busy[i] is set when some level above i is pending
  assign upper_busy[NLVL-1] = 1'b0;
  genvar g;
  generate
    for (g = NLVL - 2; g >= 1; g--) begin : g_busy
      assign upper_busy[g] = upper_busy[g+1] | vec[g+1];
    end
  endgenerate
  assign upper_busy[0] = 1'b0;

  always_comb begin
    sel = '0;
    for (int i = 1; i < NLVL; i++) begin
      if (vec[i] && !upper_busy[i]) sel = LVLW'(i);
    end
  end

  assign any = |vec[NLVL-1:1];
endmodule

// File: rtl/pil_class_dec.sv
module pil_class_dec #(
  parameter int IDXW = 8,
  parameter int LVLW = 4,
  parameter logic [IDXW-1:0] EXT_BASE = 8'h10
) (
  input  logic [IDXW-1:0] idx,
  output logic            is_idle,
  output logic            is_ext
);
  assign is_idle = (idx == '0);
  assign is_ext  = (idx[IDXW-1:LVLW] == EXT_BASE[IDXW-1:LVLW]);
endmodule

// File: rtl/pil_trap_state.sv
module pil_trap_state
  import pil_pkg::*;
#(
  parameter int IDXW = 8,
  parameter int LVLW = 4,
  parameter logic [IDXW-1:0] EXT_BASE = 8'h10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            taken,
  input  logic            load,
  input  logic [IDXW-1:0] load_code,
  input  logic            any,
  input  logic [LVLW-1:0] sel,
  input  logic            is_idle,
  input  logic            is_ext,
  output logic [IDXW-1:0] idx_q,
  output logic            req_q,
  output logic            new_q
);
  pil_act_e        act;
  logic [IDXW-1:0] cand;
  logic            eligible;

  assign cand     = EXT_BASE | IDXW'(sel);
  assign eligible = is_idle | is_ext;

  always_comb begin
    if (taken)                   act = ACT_TAKEN;
    else if (load)               act = ACT_LOAD;
    else if (any && eligible)    act = ACT_SELECT;
    else if (!any && is_ext)     act = ACT_CLEAR;
    else                         act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      req_q <= 1'b0;
      new_q <= 1'b0;
    end else begin
      new_q <= 1'b0;
      case (act)
        ACT_TAKEN: begin
          idx_q <= '0;
          req_q <= 1'b0;
        end
        ACT_LOAD:  idx_q <= load_code;
        ACT_SELECT: begin
          if (cand != idx_q) begin
            idx_q <= cand;
            req_q <= 1'b1;
            new_q <= 1'b1;
          end
        end
        ACT_CLEAR: begin
          idx_q <= '0;
          req_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pil_tracker.sv
module pil_tracker #(
  parameter int NLVL = 16,
  parameter int IDXW = 8,
  parameter logic [IDXW-1:0] EXT_BASE = 8'h10,
  localparam int LVLW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] lvl_pend,
  input  logic            trap_load,
  input  logic [IDXW-1:0] trap_code,
  input  logic            trap_taken,
  output logic [IDXW-1:0] trap_idx,
  output logic            irq_req,
  output logic            irq_new
);
  logic            any;
  logic [LVLW-1:0] sel;
  logic            is_idle;
  logic            is_ext;

  pil_prio_enc #(.NLVL(NLVL)) u_enc (
    .vec (lvl_pend),
    .any (any),
    .sel (sel)
  );

  pil_class_dec #(.IDXW(IDXW), .LVLW(LVLW), .EXT_BASE(EXT_BASE)) u_cls (
    .idx     (trap_idx),
    .is_idle (is_idle),
    .is_ext  (is_ext)
  );

  pil_trap_state #(.IDXW(IDXW), .LVLW(LVLW), .EXT_BASE(EXT_BASE)) u_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .taken     (trap_taken),
    .load      (trap_load),
    .load_code (trap_code),
    .any       (any),
    .sel       (sel),
    .is_idle   (is_idle),
    .is_ext    (is_ext),
    .idx_q     (trap_idx),
    .req_q     (irq_req),
    .new_q     (irq_new)
  );
endmodule

// File: rtl/pil_tracker_chk.sv
module pil_tracker_chk #(
  parameter int NLVL = 16,
  parameter int IDXW = 8,
  parameter logic [IDXW-1:0] EXT_BASE = 8'h10,
  localparam int LVLW = $clog2(NLVL)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NLVL-1:0] lvl_pend,
  input logic            trap_load,
  input logic [IDXW-1:0] trap_code,
  input logic            trap_taken,
  input logic [IDXW-1:0] trap_idx,
  input logic            irq_req,
  input logic            irq_new
);
  logic cur_ext;
  logic cur_foreign;
  assign cur_ext     = trap_idx[IDXW-1:LVLW] == EXT_BASE[IDXW-1:LVLW];
  assign cur_foreign = (trap_idx != '0) && !cur_ext;

  // R3: a pulse always comes with a changed index and a raised request
  a_r3_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    irq_new |-> (irq_req && trap_idx != $past(trap_idx)));

  // R3: the pulse lasts one cycle when nothing else moves
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_new && !trap_taken && !trap_load && $stable(lvl_pend)) |=> !irq_new);

  // R2: a pulsed index is an external trap with a nonzero level
  a_r2_pulse_class: assert property (@(posedge clk) disable iff (!rst_n)
    irq_new |-> (cur_ext && trap_idx[LVLW-1:0] != '0));

  // R5: empty vector retires an external trap
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_taken && !trap_load && cur_ext && lvl_pend[NLVL-1:1] == '0)
      |=> (trap_idx == '0 && !irq_req));

  // R6: a foreign trap is not disturbed by levels
  a_r6_foreign_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_taken && !trap_load && cur_foreign) |=> ($stable(trap_idx) && !irq_new));

  // R7: taking a trap clears index and request
  a_r7_taken: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> (trap_idx == '0 && !irq_req && !irq_new));

  // R8: a load writes the code without a pulse
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_load && !trap_taken) |=> (trap_idx == $past(trap_code) && !irq_new));
endmodule

bind pil_tracker pil_tracker_chk #(.NLVL(NLVL), .IDXW(IDXW), .EXT_BASE(EXT_BASE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lvl_pend   (lvl_pend),
  .trap_load  (trap_load),
  .trap_code  (trap_code),
  .trap_taken (trap_taken),
  .trap_idx   (trap_idx),
  .irq_req    (irq_req),
  .irq_new    (irq_new)
);

// File: tb/pil_tracker_test.sv
`timescale 1ns/1ps
module pil_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] lvl_pend = '0;
  logic        trap_load = 1'b0;
  logic [7:0]  trap_code = '0;
  logic        trap_taken = 1'b0;
  logic [7:0]  trap_idx;
  logic        irq_req;
  logic        irq_new;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [7:0] BASE = 8'h10;

  always #4 clk = ~clk;

  pil_tracker uut (
    .clk(clk), .rst_n(rst_n), .lvl_pend(lvl_pend), .trap_load(trap_load),
    .trap_code(trap_code), .trap_taken(trap_taken), .trap_idx(trap_idx),
    .irq_req(irq_req), .irq_new(irq_new)
  );

  task automatic check(string req, logic [7:0] idx_e, logic req_e, logic new_e);
    n_run++;
    if (trap_idx !== idx_e || irq_req !== req_e || irq_new !== new_e) begin
      n_fail++;
      $display("FAIL %s: idx=%h req=%b new=%b expected idx=%h req=%b new=%b",
               req, trap_idx, irq_req, irq_new, idx_e, req_e, new_e);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; lvl_pend = '0; trap_load = 0; trap_taken = 0;
    tick(); tick();
    check("R1 during reset", 8'h00, 0, 0);
    rst_n = 1'b1;
    tick();
    check("R1 after reset", 8'h00, 0, 0);
  endtask

  task automatic t_priority();
    lvl_pend = 16'h0020; tick();
    check("R2 single level 5", BASE | 8'd5, 1, 1);
    tick();
    check("R3 same level no pulse", BASE | 8'd5, 1, 0);
    lvl_pend = 16'h0220; tick();
    check("R3 higher level 9 pulses", BASE | 8'd9, 1, 1);
    lvl_pend = 16'h0224; tick();
    check("R3 lower level added no change", BASE | 8'd9, 1, 0);
    lvl_pend = 16'h8224; tick();
    check("R2 level 15 wins", BASE | 8'd15, 1, 1);
    lvl_pend = 16'h0004; tick();
    check("R4 ext trap reselects level 2", BASE | 8'd2, 1, 1);
    lvl_pend = 16'h0000; tick();
    check("R5 empty clears", 8'h00, 0, 0);
  endtask

  task automatic t_bit0();
    lvl_pend = 16'h0001; tick();
    check("R2 bit0 ignored", 8'h00, 0, 0);
    lvl_pend = 16'h0003; tick();
    check("R2 level 1 selected", BASE | 8'd1, 1, 1);
    lvl_pend = 16'h0001; tick();
    check("R5 only bit0 left clears", 8'h00, 0, 0);
    lvl_pend = 16'h0000;
  endtask

  task automatic t_foreign();
    trap_code = 8'h07; trap_load = 1; tick();
    trap_load = 0;
    check("R8 load foreign code", 8'h07, 0, 0);
    lvl_pend = 16'h0008; tick();
    check("R6 foreign held vs level 3", 8'h07, 0, 0);
    lvl_pend = 16'h0000; tick();
    check("R6 foreign held vs empty", 8'h07, 0, 0);
    trap_code = 8'h2A; trap_load = 1; tick();
    trap_load = 0;
    lvl_pend = 16'h4000; tick();
    check("R6 foreign 0x2A held vs level 14", 8'h2A, 0, 0);
    trap_taken = 1; tick();
    trap_taken = 0;
    check("R7 taken clears foreign", 8'h00, 0, 0);
    tick();
    check("R4 idle picks level 14", BASE | 8'd14, 1, 1);
  endtask

  task automatic t_taken();
    lvl_pend = 16'h1000;
    trap_taken = 1; trap_load = 1; trap_code = 8'h05; tick();
    trap_taken = 0; trap_load = 0;
    check("R7 taken beats load and select", 8'h00, 0, 0);
    tick();
    check("R3 reselect after taken", BASE | 8'd12, 1, 1);
    trap_code = 8'h1C; trap_load = 1; tick();
    trap_load = 0;
    check("R8 load keeps request no pulse", 8'h1C, 1, 0);
    lvl_pend = 16'h0000; tick();
    check("R5 clear after load of ext code", 8'h00, 0, 0);
  endtask

  initial begin
    t_reset();
    t_priority();
    t_bit0();
    t_foreign();
    t_taken();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule